// File: doc/BRIEF.md
# Memory Execution Witness Checker

This block judges whether one recorded multiprocessor execution is allowed under a selected memory model. The execution is given as up to eight memory events and four edge sets over those events: per-processor program order, the reads-from pairing, per-location write coherence order and intra-core data dependence. The checker derives the from-read relation. It splits reads-from into cross-processor and same-processor parts. It then decides well-formedness of the given relations and tests three relation graphs for cycles. Each cycle test runs by repeated squaring of the graph's reachability matrix.

A start pulse copies the whole execution and the model choice into the block. A fixed number of cycles later a one-cycle done pulse appears, together with an overall verdict and one flag per failed condition. These results hold until the next done pulse. Event kinds are encoded as 0 = read, 1 = write and 2 = fence. Each relation is a flat N*N bit vector in which bit a*N+b set means an edge from event a to event b. For reads-from the edge runs from the writer to the reader.

Top module: `witness_check`

## Requirements
- R1: When `start` is high and the block is idle, the inputs are captured and `busy` rises. `done` is high for exactly one cycle, sampled 5 cycles after the capturing edge (clog2(N)+2 for N = 8).
- R2: A `start` pulse while `busy` is high is ignored. The result reported belongs to the first captured execution, and no second `done` follows.
- R3: After reset, `busy`, `done`, `valid` and every failure flag are 0. The result outputs change only together with a `done` pulse, whatever the inputs do in between.
- R4: `rf_bad` is set when a used read has zero or several sources. It is also set when a reads-from edge does not run from a write to a read of the same location and value.
- R5: `co_bad` is set when two distinct used writes to one location are not ordered in exactly one direction. It is also set when a coherence edge touches a non-write, links different locations or is a self edge.
- R6: A from-read edge runs from read r to write w when r reads from some w0, w0 is coherence-before w, and r, w share a location. `uniproc_bad` is set when reads-from, coherence, from-read and same-location program order between memory accesses together contain a cycle.
- R7: `thin_air` is set when reads-from together with data dependence contain a cycle.
- R8: With `model_tso` = 0, all program-order pairs and all of reads-from are global. `ghb_cycle` is set when program order, reads-from, coherence and from-read together contain a cycle.
- R9: With `model_tso` = 1, write-then-read program-order pairs and same-processor reads-from edges are left out of the global graph.
- R10: Program-order pairs with a fence on either side stay in the global graph under both models.
- R11: `valid` is 1 exactly when none of `rf_bad`, `co_bad`, `thin_air`, `uniproc_bad`, `ghb_cycle` is set.
- R12: Events whose `ev_used` bit is 0 take part in no relation and no check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the execution and begin checking |
| model_tso | input | 1 | 0 = sequential consistency, 1 = store-buffer (TSO) model |
| ev_used | input | N | Event i takes part when bit i is 1 |
| ev_kind | input | 2*N | Event kinds, 2 bits each: 0 read, 1 write, 2 fence |
| ev_proc | input | PW*N | Processor id per event |
| ev_loc | input | LW*N | Location per event |
| ev_val | input | VW*N | Value per event |
| rel_po | input | N*N | Program order edges |
| rel_rf | input | N*N | Reads-from edges, writer to reader |
| rel_co | input | N*N | Coherence order edges |
| rel_dep | input | N*N | Data dependence edges |
| busy | output | 1 | A check is in progress |
| done | output | 1 | One-cycle pulse, results updated |
| valid | output | 1 | Execution allowed under the model |
| rf_bad | output | 1 | Reads-from not well formed |
| co_bad | output | 1 | Coherence order not well formed |
| thin_air | output | 1 | Dependence cycle found |
| uniproc_bad | output | 1 | Per-location order cycle found |
| ghb_cycle | output | 1 | Global happens-before cycle found |

## Verification
Several conditions can fail at the same time, and a new start can arrive in the same cycle as the result. One test executions is a thin-air pattern whose dependence cycle also closes a global ordering cycle. For that case the bench requires `thin_air` and `ghb_cycle` to rise together in one done pulse while `uniproc_bad` stays clear. A second start is given while a check runs, with a different model selected. That case is judged by the done latency, the absence of a second pulse, and the first model's verdict.

// File: rtl/witness_check.sv
module witness_check #(
  parameter int N  = 8,
  parameter int PW = 2,
  parameter int LW = 2,
  parameter int VW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              model_tso,
  input  logic [N-1:0]      ev_used,
  input  logic [2*N-1:0]    ev_kind,
  input  logic [PW*N-1:0]   ev_proc,
  input  logic [LW*N-1:0]   ev_loc,
  input  logic [VW*N-1:0]   ev_val,
  input  logic [N*N-1:0]    rel_po,
  input  logic [N*N-1:0]    rel_rf,
  input  logic [N*N-1:0]    rel_co,
  input  logic [N*N-1:0]    rel_dep,
  output logic              busy,
  output logic              done,
  output logic              valid,
  output logic              rf_bad,
  output logic              co_bad,
  output logic              thin_air,
  output logic              uniproc_bad,
  output logic              ghb_cycle
);
  localparam int NN     = N * N;
  localparam int PASSES = (N > 2) ? $clog2(N) : 1;
  localparam int CW     = $clog2(PASSES) + 1;

  typedef enum logic [1:0] {S_IDLE, S_BUILD, S_SQ, S_FIN} st_t;
  st_t st;
  logic [CW-1:0] pass;

  logic            tso_q;
  logic [N-1:0]    u_q;
  logic [2*N-1:0]  k_q;
  logic [PW*N-1:0] p_q;
  logic [LW*N-1:0] l_q;
  logic [VW*N-1:0] v_q;
  logic [NN-1:0]   po_q, rf_q, co_q, dp_q;

  logic [N-1:0]  isr, isw;
  logic [NN-1:0] samel, samep, samev, pm;
  logic [NN-1:0] po_m, rf_m, co_m, dp_m, fr, poloc, ppo, grf;
  logic [NN-1:0] g_uni, g_thin, g_ghb;
  logic [NN-1:0] cl_uni, cl_thin, cl_ghb;
  logic          rfb, cob, acc;
  int            cnt;

  function automatic logic [NN-1:0] square(input logic [NN-1:0] m);
    logic [NN-1:0] r;
    r = m;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        for (int k = 0; k < N; k++)
          r[i*N+j] = r[i*N+j] | (m[i*N+k] & m[k*N+j]);
    return r;
  endfunction

  function automatic logic has_loop(input logic [NN-1:0] m);
    logic h;
    h = 1'b0;
    for (int i = 0; i < N; i++) h = h | m[i*N+i];
    return h;
  endfunction

  always_comb begin
    for (int i = 0; i < N; i++) begin
      isr[i] = u_q[i] && (k_q[2*i +: 2] == 2'd0);
      isw[i] = u_q[i] && (k_q[2*i +: 2] == 2'd1);
    end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        samel[i*N+j] = l_q[i*LW +: LW] == l_q[j*LW +: LW];
        samep[i*N+j] = p_q[i*PW +: PW] == p_q[j*PW +: PW];
        samev[i*N+j] = v_q[i*VW +: VW] == v_q[j*VW +: VW];
        pm[i*N+j]    = u_q[i] & u_q[j];
      end
  end

  assign po_m = po_q & pm;
  assign rf_m = rf_q & pm;
  assign co_m = co_q & pm;
  assign dp_m = dp_q & pm;

  always_comb begin
    rfb = 1'b0;
    cob = 1'b0;
    cnt = 0;
    acc = 1'b0;
    fr = '0;
    poloc = '0;
    ppo = '0;
    for (int r = 0; r < N; r++) begin
      cnt = 0;
      for (int w = 0; w < N; w++) cnt = cnt + int'(rf_m[w*N+r]);
      if (isr[r] && cnt != 1) rfb = 1'b1;
    end
    for (int w = 0; w < N; w++)
      for (int r = 0; r < N; r++)
        if (rf_m[w*N+r] && !(isw[w] && isr[r] && samel[w*N+r] && samev[w*N+r]))
          rfb = 1'b1;
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        if (co_m[a*N+b] && !(isw[a] && isw[b] && samel[a*N+b] && a != b))
          cob = 1'b1;
        if (a < b && isw[a] && isw[b] && samel[a*N+b] && (co_m[a*N+b] == co_m[b*N+a]))
          cob = 1'b1;
      end
    for (int r = 0; r < N; r++)
      for (int w = 0; w < N; w++) begin
        acc = 1'b0;
        for (int w0 = 0; w0 < N; w0++) acc = acc | (rf_m[w0*N+r] & co_m[w0*N+w]);
        fr[r*N+w] = isr[r] & isw[w] & samel[r*N+w] & acc;
      end
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        poloc[i*N+j] = po_m[i*N+j] & samel[i*N+j] & (isr[i] | isw[i]) & (isr[j] | isw[j]);
        ppo[i*N+j]   = po_m[i*N+j] & ~(tso_q & isw[i] & isr[j]);
      end
  end

  assign grf    = tso_q ? (rf_m & ~samep) : rf_m;
  assign g_uni  = rf_m | co_m | fr | poloc;
  assign g_thin = rf_m | dp_m;
  assign g_ghb  = ppo | grf | co_m | fr;
  assign busy   = st != S_IDLE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pass <= '0;
      tso_q <= 1'b0;
      u_q <= '0;
      k_q <= '0;
      p_q <= '0;
      l_q <= '0;
      v_q <= '0;
      po_q <= '0;
      rf_q <= '0;
      co_q <= '0;
      dp_q <= '0;
      cl_uni <= '0;
      cl_thin <= '0;
      cl_ghb <= '0;
      done <= 1'b0;
      valid <= 1'b0;
      rf_bad <= 1'b0;
      co_bad <= 1'b0;
      thin_air <= 1'b0;
      uniproc_bad <= 1'b0;
      ghb_cycle <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          tso_q <= model_tso;
          u_q <= ev_used;
          k_q <= ev_kind;
          p_q <= ev_proc;
          l_q <= ev_loc;
          v_q <= ev_val;
          po_q <= rel_po;
          rf_q <= rel_rf;
          co_q <= rel_co;
          dp_q <= rel_dep;
          st <= S_BUILD;
        end
        S_BUILD: begin
          cl_uni <= g_uni;
          cl_thin <= g_thin;
          cl_ghb <= g_ghb;
          pass <= '0;
          st <= S_SQ;
        end
        S_SQ: begin
          cl_uni <= square(cl_uni);
          cl_thin <= square(cl_thin);
          cl_ghb <= square(cl_ghb);
          pass <= pass + 1'b1;
          if (pass == CW'(PASSES - 1)) st <= S_FIN;
        end
        default: begin
          rf_bad <= rfb;
          co_bad <= cob;
          thin_air <= has_loop(cl_thin);
          uniproc_bad <= has_loop(cl_uni);
          ghb_cycle <= has_loop(cl_ghb);
          valid <= !(rfb || cob || has_loop(cl_thin) || has_loop(cl_uni) || has_loop(cl_ghb));
          done <= 1'b1;
          st <= S_IDLE;
        end
      endcase
    end
  end
endmodule

module witness_check_props #(
  parameter int N = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic valid,
  input logic rf_bad,
  input logic co_bad,
  input logic thin_air,
  input logic uniproc_bad,
  input logic ghb_cycle
);
  localparam int PASSES = (N > 2) ? $clog2(N) : 1;
  localparam logic [7:0] AGE_AT_DONE = 8'(PASSES + 3);

  logic [7:0] age;
  logic [5:0] res;
  assign res = {valid, rf_bad, co_bad, thin_air, uniproc_bad, ghb_cycle};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (start && !busy) age <= 8'd1;
    else if (done) age <= '0;
    else if (age != 8'd0 && age != 8'hFF) age <= age + 8'd1;
  end

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> age == AGE_AT_DONE);
  assert_busy_on_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> (busy || done));
  assert_result_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(res));
endmodule

bind witness_check witness_check_props #(.N(N)) u_witness_check_props (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .valid(valid), .rf_bad(rf_bad), .co_bad(co_bad), .thin_air(thin_air),
  .uniproc_bad(uniproc_bad), .ghb_cycle(ghb_cycle)
);

// File: tb/test_witness_check.sv
`timescale 1ns/1ps
module test_witness_check;
  localparam int N = 8, PW = 2, LW = 2, VW = 4;
  localparam int PO = 0, RF = 1, CO = 2, DP = 3;
  localparam int RD = 0, WR = 1, FN = 2;
  localparam int LAT = 5;

  logic clk = 0, rst_n = 0, start = 0, tso = 0;
  logic [N-1:0] used;
  logic [2*N-1:0] kind;
  logic [PW*N-1:0] proc;
  logic [LW*N-1:0] loc;
  logic [VW*N-1:0] val;
  logic [N*N-1:0] po, rf, co, dp;
  logic busy, done, valid, rf_bad, co_bad, thin_air, uniproc_bad, ghb_cycle;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  witness_check #(.N(N), .PW(PW), .LW(LW), .VW(VW)) i_witness_check (
    .clk(clk), .rst_n(rst_n), .start(start), .model_tso(tso), .ev_used(used),
    .ev_kind(kind), .ev_proc(proc), .ev_loc(loc), .ev_val(val), .rel_po(po),
    .rel_rf(rf), .rel_co(co), .rel_dep(dp), .busy(busy), .done(done),
    .valid(valid), .rf_bad(rf_bad), .co_bad(co_bad), .thin_air(thin_air),
    .uniproc_bad(uniproc_bad), .ghb_cycle(ghb_cycle));

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clr(bit m);
    used = '0; kind = '0; proc = '0; loc = '0; val = '0;
    po = '0; rf = '0; co = '0; dp = '0; tso = m;
  endtask

  task automatic ev(int i, int kd, int pr, int lc, int vl);
    used[i] = 1'b1;
    kind[2*i +: 2] = 2'(kd);
    proc[PW*i +: PW] = PW'(pr);
    loc[LW*i +: LW] = LW'(lc);
    val[VW*i +: VW] = VW'(vl);
  endtask

  task automatic rel(int which, int a, int b);
    case (which)
      PO: po[a*N+b] = 1'b1;
      RF: rf[a*N+b] = 1'b1;
      CO: co[a*N+b] = 1'b1;
      default: dp[a*N+b] = 1'b1;
    endcase
  endtask

  task automatic run();
    int cyc;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk("R1", "busy after accept", int'(busy), 1);
    cyc = 0;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    chk("R1", "done latency", cyc, LAT);
    @(negedge clk);
    chk("R1", "done width", int'(done), 0);
  endtask

  task automatic expect_res(string req, int rb, int cb, int th, int un, int gh);
    int v;
    v = (rb | cb | th | un | gh) ? 0 : 1;
    chk(req, "flags {rf,co,thin,uni,ghb}",
        int'({rf_bad, co_bad, thin_air, uniproc_bad, ghb_cycle}),
        (rb << 4) | (cb << 3) | (th << 2) | (un << 1) | gh);
    chk("R11", {req, " valid"}, int'(valid), v);
  endtask

  // store-buffer shape: 0 Wx0,1 Wy0 (p3); 2 Wx1,3 Ry0 (p0); 4 Wy1,5 Rx0 (p1)
  task automatic build_sb(bit m);
    clr(m);
    ev(0, WR, 3, 0, 0); ev(1, WR, 3, 1, 0);
    ev(2, WR, 0, 0, 1); ev(3, RD, 0, 1, 0);
    ev(4, WR, 1, 1, 1); ev(5, RD, 1, 0, 0);
    rel(PO, 2, 3); rel(PO, 4, 5);
    rel(RF, 1, 3); rel(RF, 0, 5);
    rel(CO, 0, 2); rel(CO, 1, 4);
  endtask

  task automatic t_reset();
    chk("R3", "reset busy", int'(busy), 0);
    chk("R3", "reset done", int'(done), 0);
    chk("R3", "reset result", int'({valid, rf_bad, co_bad, thin_air, uniproc_bad, ghb_cycle}), 0);
  endtask

  task automatic t_sb();
    build_sb(0); run(); expect_res("R8 sb sc", 0, 0, 0, 0, 1);
    build_sb(1); run(); expect_res("R9 sb tso", 0, 0, 0, 0, 0);
  endtask

  task automatic t_fence();
    build_sb(1);
    ev(6, FN, 0, 0, 0); ev(7, FN, 1, 0, 0);
    rel(PO, 2, 6); rel(PO, 6, 3); rel(PO, 4, 7); rel(PO, 7, 5);
    run(); expect_res("R10 fenced sb tso", 0, 0, 0, 0, 1);
  endtask

  task automatic build_rfi(bit m);
    clr(m);
    ev(0, WR, 3, 0, 0); ev(1, WR, 3, 1, 0);
    ev(2, WR, 0, 0, 1); ev(3, RD, 0, 0, 1); ev(4, RD, 0, 1, 0);
    ev(5, WR, 1, 1, 1); ev(6, RD, 1, 1, 1); ev(7, RD, 1, 0, 0);
    rel(PO, 2, 3); rel(PO, 2, 4); rel(PO, 3, 4);
    rel(PO, 5, 6); rel(PO, 5, 7); rel(PO, 6, 7);
    rel(RF, 2, 3); rel(RF, 1, 4); rel(RF, 5, 6); rel(RF, 0, 7);
    rel(CO, 0, 2); rel(CO, 1, 5);
  endtask

  task automatic t_rfi();
    build_rfi(1); run(); expect_res("R9 own-write forwarding tso", 0, 0, 0, 0, 0);
    build_rfi(0); run(); expect_res("R8 own-write forwarding sc", 0, 0, 0, 0, 1);
  endtask

  task automatic t_rf_bad();
    build_sb(1); rf[1*N+3] = 1'b0;
    run(); expect_res("R4 read without source", 1, 0, 0, 0, 0);
    build_sb(1); val[VW*3 +: VW] = 4'd1;
    run(); expect_res("R4 value mismatch", 1, 0, 0, 0, 0);
  endtask

  task automatic t_co_bad();
    build_sb(1); co[0*N+2] = 1'b0;
    run(); expect_res("R5 unordered writes", 0, 1, 0, 0, 0);
  endtask

  task automatic t_uniproc();
    clr(1);
    ev(0, WR, 3, 0, 0); ev(1, WR, 0, 0, 1); ev(2, RD, 0, 0, 0);
    rel(PO, 1, 2); rel(RF, 0, 2); rel(CO, 0, 1);
    run(); expect_res("R6 stale read after own write", 0, 0, 0, 1, 0);
  endtask

  task automatic t_thin();
    clr(0);
    ev(0, RD, 0, 0, 1); ev(1, WR, 0, 1, 1); ev(2, RD, 1, 1, 1); ev(3, WR, 1, 0, 1);
    rel(PO, 0, 1); rel(PO, 2, 3); rel(DP, 0, 1); rel(DP, 2, 3);
    rel(RF, 3, 0); rel(RF, 1, 2);
    run(); expect_res("R7 dependence loop", 0, 0, 1, 0, 1);
  endtask

  task automatic t_unused();
    build_sb(1);
    kind[2*7 +: 2] = 2'(RD); rf[7*N+7] = 1'b1; po[7*N+2] = 1'b1; co[7*N+0] = 1'b1;
    run(); expect_res("R12 unused event", 0, 0, 0, 0, 0);
  endtask

  task automatic t_busy_start();
    int cyc;
    build_sb(0);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    @(negedge clk) begin build_sb(1); start = 1; end
    @(negedge clk) start = 0;
    cyc = 2;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    chk("R2", "latency with extra start", cyc, LAT);
    expect_res("R2 first execution kept", 0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R2", "no restart busy", int'(busy), 0);
    repeat (LAT + 1) @(negedge clk);
    chk("R2", "no second done", int'(done), 0);
  endtask

  task automatic t_hold();
    build_sb(0); run();
    build_sb(1); rf = '0;
    repeat (4) @(negedge clk);
    chk("R3", "done stays low", int'(done), 0);
    expect_res("R3 results held", 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clr(0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_sb();
    t_fence();
    t_rfi();
    t_rf_bad();
    t_co_bad();
    t_uniproc();
    t_thin();
    t_unused();
    t_busy_start();
    t_hold();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule